// File: doc/BRIEF.md
# Shift and Rotate Unit

This block is the combinational shift/rotate datapath of a 16-bit processor's execute stage. An upstream decoder presents a 6-bit operation code, the destination operand, a count operand and the current carry and overflow flags. In the same cycle the unit returns the shifted or rotated word, the new carry and overflow flag values, and a strobe that tells the flag register whether to refresh its zero and sign bits from the result. Operand fetch and writeback happen outside the block.

Six operations are served. There are logical shifts in both directions, plain rotates in both directions, and rotates that pass through the carry flag. Each family reduces its count in its own way: plain shifts saturate, plain rotates wrap modulo the word width, and carry rotates wrap modulo the width plus one. When an operation's effective count is zero, every output copies its input. The overflow flag is recomputed only when exactly one position is moved.

Top module: `shift_rotate_unit`

## Requirements
- R1: Operation codes are 0x06 shift left, 0x07 shift right, 0x20 rotate right, 0x23 rotate left, 0x27 rotate left through carry and 0x28 rotate right through carry. For any other code, resultOut equals destIn, carryOut equals carryIn and overflowOut equals overflowIn.
- R2: Shift left (0x06) brings zeros into the low end. carryOut is the last bit pushed out of bit 15. A count of 16 or more gives a zero result, and a count above 16 also gives carry 0.
- R3: Shift right (0x07) brings zeros into the high end. carryOut is the last bit pushed out of bit 0. A count of 16 or more gives a zero result, and a count above 16 also gives carry 0.
- R4: Rotate left (0x23) and rotate right (0x20) use the count modulo 16. Bits leaving one end re-enter at the other. carryOut equals the last bit that crossed: result bit 0 for left, result bit 15 for right.
- R5: Rotate left through carry (0x27) uses the count modulo 17. It rotates the 17-bit word {carry, operand}, with carry above bit 15. carryOut is bit 16 of the rotated word.
- R6: Rotate right through carry (0x28) uses the count modulo 17. It rotates the 17-bit word {operand, carry}, with carry below bit 0. carryOut is bit 0 of the rotated word.
- R7: When the effective count is 0, resultOut equals destIn, carryOut equals carryIn and overflowOut equals overflowIn.
- R8: When the effective count is 1, overflowOut is resultOut[15] XOR destIn[15].
- R9: When the effective count is neither 0 nor 1, overflowOut equals overflowIn.
- R10: zeroSignWe is 1 exactly when opCode is 0x06, and 0 for every other code.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| opCode | input | 6 | Operation code |
| destIn | input | WIDTH | Operand to shift or rotate |
| countIn | input | CNT_W | Raw count operand |
| carryIn | input | 1 | Current carry flag |
| overflowIn | input | 1 | Current overflow flag |
| resultOut | output | WIDTH | Shifted or rotated word |
| carryOut | output | 1 | New carry flag |
| overflowOut | output | 1 | New overflow flag |
| zeroSignWe | output | 1 | Refresh zero and sign flags from resultOut |

## Verification
The bench builds the unit with its default WIDTH of 16 and CNT_W of 16. With these values the 16-bit count reaches far beyond both moduli, so wrap-around at 16 and 17 and shift saturation are all exercised. Random counts are drawn mostly from 0 to 40, which puts many draws on the 0, 1, 16 and 17 boundaries, and some from the full 16-bit range. Directed cases fix the carry value entering the vacated bit and the overflow change on single-position moves.

// File: rtl/shrot_pkg.sv
package shrot_pkg;

  localparam logic [5:0] OP_SHL = 6'h06;
  localparam logic [5:0] OP_SHR = 6'h07;
  localparam logic [5:0] OP_ROR = 6'h20;
  localparam logic [5:0] OP_ROL = 6'h23;
  localparam logic [5:0] OP_RCL = 6'h27;
  localparam logic [5:0] OP_RCR = 6'h28;

  typedef enum logic [2:0] {
    M_PASS = 3'd0,
    M_SHL  = 3'd1,
    M_SHR  = 3'd2,
    M_ROL  = 3'd3,
    M_ROR  = 3'd4,
    M_RCL  = 3'd5,
    M_RCR  = 3'd6
  } shMode_e;

  // strobes from control to datapath
  typedef struct packed {
    shMode_e mode;
    logic    active;   // effective count non-zero and known op
    logic    oneStep;  // effective count exactly one
    logic    zsWe;     // zero/sign refresh
  } shStrobe_t;

endpackage

// File: rtl/shrot_ctrl.sv
module shrot_ctrl
  import shrot_pkg::*;
#(
  parameter int WIDTH = 16,
  parameter int CNT_W = 16,
  parameter int AW    = $clog2(WIDTH + 2)
) (
  input  logic [5:0]       opCode,
  input  logic [CNT_W-1:0] countIn,
  output shStrobe_t        strobe,
  output logic [AW-1:0]    amt
);

  localparam logic [CNT_W-1:0] SAT_CNT  = CNT_W'(WIDTH + 1);
  localparam logic [CNT_W-1:0] MOD_ROT  = CNT_W'(WIDTH);
  localparam logic [CNT_W-1:0] MOD_RCAR = CNT_W'(WIDTH + 1);

  shMode_e          mode;
  logic [CNT_W-1:0] effCount;

  always_comb begin
    case (opCode)
      OP_SHL:  mode = M_SHL;
      OP_SHR:  mode = M_SHR;
      OP_ROL:  mode = M_ROL;
      OP_ROR:  mode = M_ROR;
      OP_RCL:  mode = M_RCL;
      OP_RCR:  mode = M_RCR;
      default: mode = M_PASS;
    endcase
  end

  always_comb begin
    case (mode)
      M_SHL, M_SHR: effCount = (countIn > SAT_CNT) ? SAT_CNT : countIn;
      M_ROL, M_ROR: effCount = countIn % MOD_ROT;
      M_RCL, M_RCR: effCount = countIn % MOD_RCAR;
      default:      effCount = '0;
    endcase
  end

  assign amt            = effCount[AW-1:0];
  assign strobe.mode    = mode;
  assign strobe.active  = (mode != M_PASS) && (effCount != '0);
  assign strobe.oneStep = (mode != M_PASS) && (effCount == CNT_W'(1));
  assign strobe.zsWe    = (mode == M_SHL);

  // plain rotate amount stays below the word width (R4)
  always_comb begin
    if (mode == M_ROL || mode == M_ROR)
      p_rot_amt_bound_r4: assert (amt < AW'(WIDTH))
        else $error("rotate amount %0d out of range", amt);
  end

  // carry rotate amount never exceeds the word width (R5, R6)
  always_comb begin
    if (mode == M_RCL || mode == M_RCR)
      p_rcar_amt_bound_r5: assert (amt <= AW'(WIDTH))
        else $error("carry rotate amount %0d out of range", amt);
  end

endmodule

// File: rtl/shrot_datapath.sv
module shrot_datapath
  import shrot_pkg::*;
#(
  parameter int WIDTH = 16,
  parameter int AW    = $clog2(WIDTH + 2)
) (
  input  shStrobe_t        strobe,
  input  logic [AW-1:0]    amt,
  input  logic [WIDTH-1:0] destIn,
  input  logic             carryIn,
  input  logic             overflowIn,
  output logic [WIDTH-1:0] resultOut,
  output logic             carryOut,
  output logic             overflowOut
);

  localparam int XW = WIDTH + 1;

  logic [WIDTH-1:0]   rawResult;
  logic               rawCarry;
  logic [XW-1:0]      shlWord, shrWord;
  logic [2*WIDTH-1:0] rotLeftDbl, rotRightDbl;
  logic [2*XW-1:0]    rclDbl, rcrDbl;
  logic [XW-1:0]      rclWord, rcrWord;

  // logical shifts on a one-bit extended word; the extra bit catches carry
  assign shlWord = {1'b0, destIn} << amt;
  assign shrWord = {destIn, 1'b0} >> amt;

  // plain rotates via a doubled word
  assign rotLeftDbl  = {destIn, destIn} << amt;
  assign rotRightDbl = {destIn, destIn} >> amt;

  // carry rotates on the (WIDTH+1)-bit word, doubled
  assign rclDbl  = {carryIn, destIn, carryIn, destIn} << amt;
  assign rcrDbl  = {destIn, carryIn, destIn, carryIn} >> amt;
  assign rclWord = rclDbl[2*XW-1:XW];
  assign rcrWord = rcrDbl[XW-1:0];

  always_comb begin
    case (strobe.mode)
      M_SHL: begin
        rawResult = shlWord[WIDTH-1:0];
        rawCarry  = shlWord[WIDTH];
      end
      M_SHR: begin
        rawResult = shrWord[XW-1:1];
        rawCarry  = shrWord[0];
      end
      M_ROL: begin
        rawResult = rotLeftDbl[2*WIDTH-1:WIDTH];
        rawCarry  = rotLeftDbl[WIDTH];
      end
      M_ROR: begin
        rawResult = rotRightDbl[WIDTH-1:0];
        rawCarry  = rotRightDbl[WIDTH-1];
      end
      M_RCL: begin
        rawResult = rclWord[WIDTH-1:0];
        rawCarry  = rclWord[WIDTH];
      end
      M_RCR: begin
        rawResult = rcrWord[XW-1:1];
        rawCarry  = rcrWord[0];
      end
      default: begin
        rawResult = destIn;
        rawCarry  = carryIn;
      end
    endcase
  end

  always_comb begin
    if (strobe.active) begin
      resultOut = rawResult;
      carryOut  = rawCarry;
    end else begin
      resultOut = destIn;
      carryOut  = carryIn;
    end
    if (strobe.oneStep)
      overflowOut = rawResult[WIDTH-1] ^ destIn[WIDTH-1];
    else
      overflowOut = overflowIn;
  end

  // plain rotates keep the number of set bits (R4)
  always_comb begin
    if (strobe.mode == M_ROL || strobe.mode == M_ROR)
      p_rot_popcount_r4: assert ($countones(resultOut) == $countones(destIn))
        else $error("rotate changed population count");
  end

  // carry rotates keep the set bits of carry plus word (R5)
  always_comb begin
    if (strobe.mode == M_RCL || strobe.mode == M_RCR)
      p_rcar_popcount_r5: assert ($countones({carryOut, resultOut}) ==
                                  $countones({carryIn, destIn}))
        else $error("carry rotate changed population count");
  end

  // shift left leaves the low amt bits zero (R2)
  always_comb begin
    if (strobe.mode == M_SHL && strobe.active && amt <= AW'(WIDTH))
      p_shl_lowzero_r2: assert ((resultOut & WIDTH'(({WIDTH{1'b1}} << amt) ^ {WIDTH{1'b1}})) == '0)
        else $error("shift left did not fill with zeros");
  end

  // shift right leaves the high amt bits zero (R3)
  always_comb begin
    if (strobe.mode == M_SHR && strobe.active && amt <= AW'(WIDTH))
      p_shr_highzero_r3: assert ((resultOut & WIDTH'(({WIDTH{1'b1}} >> amt) ^ {WIDTH{1'b1}})) == '0)
        else $error("shift right did not fill with zeros");
  end

endmodule

// File: rtl/shift_rotate_unit.sv
module shift_rotate_unit
  import shrot_pkg::*;
#(
  parameter int WIDTH = 16,
  parameter int CNT_W = 16
) (
  input  logic [5:0]       opCode,
  input  logic [WIDTH-1:0] destIn,
  input  logic [CNT_W-1:0] countIn,
  input  logic             carryIn,
  input  logic             overflowIn,
  output logic [WIDTH-1:0] resultOut,
  output logic             carryOut,
  output logic             overflowOut,
  output logic             zeroSignWe
);

  localparam int AW = $clog2(WIDTH + 2);

  shStrobe_t     strobe;
  logic [AW-1:0] amt;

  shrot_ctrl #(
    .WIDTH (WIDTH),
    .CNT_W (CNT_W),
    .AW    (AW)
  ) u_ctrl (
    .opCode  (opCode),
    .countIn (countIn),
    .strobe  (strobe),
    .amt     (amt)
  );

  shrot_datapath #(
    .WIDTH (WIDTH),
    .AW    (AW)
  ) u_dp (
    .strobe      (strobe),
    .amt         (amt),
    .destIn      (destIn),
    .carryIn     (carryIn),
    .overflowIn  (overflowIn),
    .resultOut   (resultOut),
    .carryOut    (carryOut),
    .overflowOut (overflowOut)
  );

  assign zeroSignWe = strobe.zsWe;

  // large left shift count flushes word and carry (R2)
  always_comb begin
    if (opCode == OP_SHL && countIn > CNT_W'(WIDTH))
      p_shl_flush_r2: assert (resultOut == '0 && !carryOut)
        else $error("oversized shift left not flushed");
  end

  // unknown codes leave everything untouched (R1)
  always_comb begin
    if (opCode != OP_SHL && opCode != OP_SHR && opCode != OP_ROL &&
        opCode != OP_ROR && opCode != OP_RCL && opCode != OP_RCR)
      p_pass_hold_r1: assert (resultOut == destIn && carryOut == carryIn &&
                              overflowOut == overflowIn && !zeroSignWe)
        else $error("unknown code altered outputs");
  end

endmodule

// File: tb/sim_shift_rotate_unit.sv
`timescale 1ns/1ps
module sim_shift_rotate_unit;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [5:0]  opCode = '0;
  logic [15:0] destIn = '0;
  logic [15:0] countIn = '0;
  logic        carryIn = 1'b0;
  logic        overflowIn = 1'b0;
  logic [15:0] resultOut;
  logic        carryOut, overflowOut, zeroSignWe;

  int nChecks = 0;
  int nFails  = 0;
  bit done    = 0;

  always #5 clk = ~clk;

  shift_rotate_unit u0 (
    .opCode(opCode), .destIn(destIn), .countIn(countIn),
    .carryIn(carryIn), .overflowIn(overflowIn),
    .resultOut(resultOut), .carryOut(carryOut),
    .overflowOut(overflowOut), .zeroSignWe(zeroSignWe)
  );

  function automatic int effCnt(input logic [5:0] op, input logic [15:0] c);
    case (op)
      6'h06, 6'h07: return (c > 16'd17) ? 17 : int'(c);
      6'h20, 6'h23: return int'(c % 16'd16);
      6'h27, 6'h28: return int'(c % 16'd17);
      default:      return 0;
    endcase
  endfunction

  function automatic string opTag(input logic [5:0] op);
    case (op)
      6'h06: return "R2";
      6'h07: return "R3";
      6'h20, 6'h23: return "R4";
      6'h27: return "R5";
      6'h28: return "R6";
      default: return "R1";
    endcase
  endfunction

  // bit-serial reference model
  task automatic model(input logic [5:0] op, input logic [15:0] d,
                       input logic [15:0] c, input logic ci, input logic oi,
                       output logic [15:0] r, output logic co, output logic oo);
    int n = effCnt(op, c);
    logic t;
    r = d; co = ci;
    for (int i = 0; i < n; i++) begin
      case (op)
        6'h06: begin co = r[15]; r = {r[14:0], 1'b0}; end
        6'h07: begin co = r[0];  r = {1'b0, r[15:1]}; end
        6'h23: begin co = r[15]; r = {r[14:0], r[15]}; end
        6'h20: begin co = r[0];  r = {r[0], r[15:1]}; end
        6'h27: begin t = r[15]; r = {r[14:0], co}; co = t; end
        6'h28: begin t = r[0];  r = {co, r[15:1]}; co = t; end
        default: ;
      endcase
    end
    oo = (n == 1) ? (r[15] ^ d[15]) : oi;
  endtask

  task automatic cmp(input string tag, input string what, input int act, input int exp);
    nChecks++;
    if (act != exp) begin
      nFails++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  task automatic runOne(input logic [5:0] op, input logic [15:0] d,
                        input logic [15:0] c, input logic ci, input logic oi,
                        input string extra);
    logic [15:0] er; logic ec, eo;
    int n;
    string rt;
    @(posedge clk);
    opCode = op; destIn = d; countIn = c; carryIn = ci; overflowIn = oi;
    model(op, d, c, ci, oi, er, ec, eo);
    n = effCnt(op, c);
    rt = (n == 0) ? "R7" : opTag(op);
    if (extra != "") rt = {rt, "/", extra};
    @(negedge clk);
    cmp(rt, "result", int'(resultOut), int'(er));
    cmp(rt, "carry", int'(carryOut), int'(ec));
    cmp((n == 1) ? "R8" : ((n == 0) ? "R7" : "R9"), "overflow", int'(overflowOut), int'(eo));
    cmp("R10", "zeroSignWe", int'(zeroSignWe), (op == 6'h06) ? 1 : 0);
  endtask

  initial begin
    #(200000 * 10);
    if (!done) begin
      nFails++; nChecks++;
      $display("FAIL watchdog expired");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
      $finish;
    end
  end

  initial begin
    logic [5:0] ops [7];
    void'($urandom(32'd1234));
    ops[0] = 6'h06; ops[1] = 6'h07; ops[2] = 6'h20; ops[3] = 6'h23;
    ops[4] = 6'h27; ops[5] = 6'h28; ops[6] = 6'h3F;
    repeat (3) @(posedge clk);
    rst = 1'b0;
    @(negedge clk);
    // reset state: all-zero inputs, code 0 passes through (R1)
    cmp("R1", "reset result", int'(resultOut), 0);
    cmp("R1", "reset carry", int'(carryOut), 0);
    cmp("R10", "reset zeroSignWe", int'(zeroSignWe), 0);

    // directed corner cases
    runOne(6'h06, 16'h8001, 16'd1,  1'b0, 1'b0, "R8");
    runOne(6'h06, 16'h8001, 16'd16, 1'b0, 1'b1, "R2");
    runOne(6'h06, 16'hFFFF, 16'd17, 1'b1, 1'b0, "R2");
    runOne(6'h06, 16'hFFFF, 16'hFFFF, 1'b1, 1'b0, "R2");
    runOne(6'h07, 16'h8001, 16'd1,  1'b0, 1'b0, "R3");
    runOne(6'h07, 16'h8000, 16'd16, 1'b0, 1'b0, "R3");
    runOne(6'h07, 16'hFFFF, 16'd40, 1'b1, 1'b1, "R3");
    runOne(6'h23, 16'h8000, 16'd1,  1'b0, 1'b0, "R4");
    runOne(6'h23, 16'h1234, 16'd16, 1'b1, 1'b1, "R7");
    runOne(6'h20, 16'h0001, 16'd33, 1'b0, 1'b0, "R4");
    runOne(6'h27, 16'h0000, 16'd1,  1'b1, 1'b0, "R5");
    runOne(6'h27, 16'hA5A5, 16'd17, 1'b1, 1'b1, "R7");
    runOne(6'h27, 16'h8000, 16'd16, 1'b0, 1'b0, "R5");
    runOne(6'h28, 16'h0000, 16'd1,  1'b1, 1'b0, "R6");
    runOne(6'h28, 16'h0001, 16'd17, 1'b0, 1'b1, "R7");
    runOne(6'h28, 16'h0001, 16'd2,  1'b0, 1'b1, "R9");
    runOne(6'h07, 16'h1234, 16'd0,  1'b1, 1'b1, "R7");
    runOne(6'h3F, 16'hBEEF, 16'd3,  1'b1, 1'b1, "R1");
    runOne(6'h00, 16'h0F0F, 16'd1,  1'b0, 1'b1, "R1");

    // constrained random
    for (int i = 0; i < 4000; i++) begin
      logic [5:0]  op = ops[$urandom % 7];
      logic [15:0] c  = ($urandom % 4 == 0) ? 16'($urandom) : 16'($urandom % 41);
      if ($urandom % 10 == 0) op = 6'($urandom);
      runOne(op, 16'($urandom), c, 1'($urandom), 1'($urandom), "");
    end

    done = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end

endmodule